// File: doc/BRIEF.md
# Six-Channel DMA Word-Slot Arbiter

This block decides which of six DMA channels owns the shared bus in each word slot. A channel raises its request bit while it has a word ready to move, and marks the word that closes its burst with its last-word bit. Every clock cycle is one word slot. The arbiter registers a one-hot grant, so a request seen in one cycle is served in the next slot at the earliest. A channel that wins the bus keeps it until it moves its last word.

Two priority modes exist. In round-robin mode all six channels rotate, with a pointer that starts after the most recent burst winner. In channel-1-high mode, a request from channel 1 takes the next slot even when another channel is in the middle of a burst. Channel 1 then keeps the bus until its own burst ends, and the displaced channel continues its burst before any other channel gets a turn. Channels 2 to 6 keep rotating among themselves. The mode input only takes effect in a cycle where no burst is in progress.

A suspend input stops new grants once the word in flight has completed, unless free-run is selected. Reset clears all burst state, selects round-robin and puts channel 1 first in line.

Top module: `dma_word_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle, and a channel is granted a slot only if its `req_i` bit was high in the cycle before.
- R2: While `rst` is high and in the first cycle after it, `gnt_o` is zero. Reset selects round-robin mode, and with all six channels requesting single-word bursts, channel 1 (bit 0) is granted first and channel 2 (bit 1) next.
- R3: In round-robin mode, a channel granted a word keeps the bus until a slot in which it is granted with its `last_i` bit high. The next burst then goes to the first requesting channel after that winner, in the order 1 to 6 with wrap-around.
- R4: With all channels requesting one-word bursts in round-robin mode, grants cycle through bit 0 up to bit 5 and back to bit 0.
- R5: In channel-1-high mode, a channel 1 request gives channel 1 the next slot, even when another channel's burst is unfinished.
- R6: Once channel 1 has started a burst in channel-1-high mode, no other channel is granted until channel 1 moves its last word. Slots in which channel 1 has no request stay empty.
- R7: When channel 1 releases the bus, a channel it displaced mid-burst gets the next slot ahead of other requesters, and continues until its own last word.
- R8: In channel-1-high mode, new bursts among channels 2 to 6 rotate in the order of R3, and channel 1 is never chosen through that rotation.
- R9: When `suspend_i` is high and `free_run_i` is low, the following slot carries no grant. A burst that was cut off continues when the suspend is removed.
- R10: When `free_run_i` is high, `suspend_i` has no effect on grants.
- R11: `ch1_high_i` (1 = channel-1-high, 0 = round-robin) is taken into the mode register only at a clock edge where no burst is in progress. The new mode governs grants from the next cycle.
- R12: A channel holding the bus mid-burst that drops its request gets empty slots. No other channel is granted until it finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one word slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ch1_high_i | input | 1 | Requested mode: 1 channel-1-high, 0 round-robin |
| free_run_i | input | 1 | 1 makes the arbiter ignore suspend |
| suspend_i | input | 1 | Stop granting after the word in flight |
| req_i | input | 6 | Per-channel word request; bit 0 is channel 1 |
| last_i | input | 6 | Per-channel flag marking the final word of a burst |
| gnt_o | output | 6 | Registered one-hot grant for the current slot |

## Verification
The hardest state to reach is a preemption that overlaps with a pending mode change. In that state a low-priority burst has been displaced by channel 1, and the mode input has already been changed back. The bench gets there by starting a pool burst under channel-1-high mode, raising channel 1 mid-burst, and stalling channel 1 with empty slots. It then flips the mode input while bursts are still live. This shows both that the displaced channel resumes first and that the mode register only reloads once every burst has closed. A second such state is a burst frozen by suspend and later continued, which the bench reaches by raising suspend between two words of a multi-word burst.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_ROUND_ROBIN = 1'b0,
    ARB_CH1_HIGH    = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dma_arb_rr_pick.sv
// Rotating first-set finder: searches from the entry after last_idx.
module dma_arb_rr_pick #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last_idx,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW:0] cand;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = '0;
    for (int k = 1; k <= N; k++) begin
      cand = {1'b0, last_idx} + (IW+1)'(k);
      if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
      if (!found && req[cand[IW-1:0]]) begin
        found = 1'b1;
        idx   = cand[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_arb_hold.sv
// Tracks which pool channel owns an unfinished burst.
module dma_arb_hold #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [IW-1:0] start_idx_i,
  input  logic          end_i,
  output logic          held_v_o,
  output logic [IW-1:0] held_idx_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_v_o   <= 1'b0;
      held_idx_o <= '0;
    end else if (start_i) begin
      held_v_o   <= 1'b1;
      held_idx_o <= start_idx_i;
    end else if (end_i) begin
      held_v_o   <= 1'b0;
    end
  end

  // R3
  hold_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (!held_v_o || end_i));
endmodule

// File: rtl/dma_word_arbiter.sv
module dma_word_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ch1_high_i,
  input  logic           free_run_i,
  input  logic           suspend_i,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] last_i,
  output logic [NCH-1:0] gnt_o
);
  localparam int IW = $clog2(NCH);
  localparam logic [IW-1:0] LAST_CH = IW'(NCH - 1);

  arb_mode_e      mode_q;
  logic           c1_busy_q;
  logic [IW-1:0]  ptr_q;
  logic           held_v;
  logic [IW-1:0]  held_idx;

  logic           halt;
  logic           held_end, held_live;
  logic           c1_end, c1_live, c1_path, c1_start;
  logic [NCH-1:0] pool_mask;
  logic           pick_found;
  logic [IW-1:0]  pick_idx;
  logic           pool_start;
  logic [NCH-1:0] gnt_nxt;
  logic           all_idle;

  assign halt      = suspend_i & ~free_run_i;
  assign held_end  = held_v & gnt_o[held_idx] & last_i[held_idx];
  assign held_live = held_v & ~held_end;
  assign c1_end    = c1_busy_q & gnt_o[0] & last_i[0];
  assign c1_live   = c1_busy_q & ~c1_end;
  assign c1_path   = (mode_q == ARB_CH1_HIGH) & (req_i[0] | c1_live);
  assign all_idle  = ~held_live & ~c1_live;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_mask
      if (g == 0) begin : g_c1
        assign pool_mask[g] = (mode_q == ARB_ROUND_ROBIN);
      end else begin : g_other
        assign pool_mask[g] = 1'b1;
      end
    end
  endgenerate

  dma_arb_rr_pick #(.N(NCH), .IW(IW)) u_pick (
    .req      (req_i & pool_mask),
    .last_idx (ptr_q),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  always_comb begin
    gnt_nxt    = '0;
    pool_start = 1'b0;
    c1_start   = 1'b0;
    if (!halt) begin
      if (c1_path) begin
        gnt_nxt[0] = req_i[0];
        c1_start   = req_i[0] & ~c1_live;
      end else if (held_live) begin
        gnt_nxt[held_idx] = req_i[held_idx];
      end else if (pick_found) begin
        gnt_nxt[pick_idx] = 1'b1;
        pool_start        = 1'b1;
      end
    end
  end

  dma_arb_hold #(.IW(IW)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .start_i     (pool_start),
    .start_idx_i (pick_idx),
    .end_i       (held_end),
    .held_v_o    (held_v),
    .held_idx_o  (held_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o     <= '0;
      mode_q    <= ARB_ROUND_ROBIN;
      c1_busy_q <= 1'b0;
      ptr_q     <= LAST_CH;
    end else begin
      gnt_o <= gnt_nxt;
      if (all_idle) mode_q <= arb_mode_e'(ch1_high_i);
      if (c1_start)    c1_busy_q <= 1'b1;
      else if (c1_end) c1_busy_q <= 1'b0;
      if (pool_start) ptr_q <= pick_idx;
    end
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_reqchk
      // R1
      gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_o[g] |-> $past(req_i[g]));
    end
  endgenerate

  // R9
  suspend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> (gnt_o == '0));

  // R5
  ch1_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == ARB_CH1_HIGH) && req_i[0] && !halt) |=> gnt_o[0]);

  // R6
  ch1_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (c1_live && !halt) |=> ((gnt_o & ~NCH'(1)) == '0));
endmodule

// File: tb/tb_dma_word_arbiter.sv
module tb_dma_word_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ch1_high_i = 1'b0;
  logic       free_run_i = 1'b0;
  logic       suspend_i = 1'b0;
  logic [5:0] req_i = '0;
  logic [5:0] last_i = '0;
  logic [5:0] gnt_o;

  int tests = 0;
  int fails = 0;

  dma_word_arbiter dut (
    .clk(clk), .rst(rst), .ch1_high_i(ch1_high_i), .free_run_i(free_run_i),
    .suspend_i(suspend_i), .req_i(req_i), .last_i(last_i), .gnt_o(gnt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // fields: [24:21] req tag, [20] ch1_high, [19] free_run, [18] suspend,
  // [17:12] req, [11:6] last, [5:0] expected grant in the following slot
  localparam logic [24:0] VEC [NV] = '{
    {4'd4, 3'b000, 6'h3f, 6'h3f, 6'h01},  // R4 rotation
    {4'd4, 3'b000, 6'h3f, 6'h3f, 6'h02},
    {4'd4, 3'b000, 6'h3f, 6'h3f, 6'h04},
    {4'd4, 3'b000, 6'h3f, 6'h3f, 6'h08},
    {4'd4, 3'b000, 6'h3f, 6'h3f, 6'h10},
    {4'd4, 3'b000, 6'h3f, 6'h3f, 6'h20},
    {4'd4, 3'b000, 6'h3f, 6'h3f, 6'h01},
    {4'd3, 3'b000, 6'h05, 6'h00, 6'h01},  // R3 hold
    {4'd3, 3'b000, 6'h05, 6'h01, 6'h04},
    {4'd3, 3'b000, 6'h05, 6'h00, 6'h04},
    {4'd3, 3'b000, 6'h05, 6'h04, 6'h01},
    {4'd12, 3'b000, 6'h04, 6'h00, 6'h00}, // R12 stall keeps bus
    {4'd12, 3'b000, 6'h05, 6'h00, 6'h01},
    {4'd3, 3'b000, 6'h01, 6'h01, 6'h01},
    {4'd3, 3'b000, 6'h00, 6'h01, 6'h00},
    {4'd9, 3'b000, 6'h02, 6'h00, 6'h02},  // R9 suspend mid-burst
    {4'd9, 3'b001, 6'h02, 6'h00, 6'h00},
    {4'd9, 3'b001, 6'h02, 6'h00, 6'h00},
    {4'd9, 3'b000, 6'h06, 6'h00, 6'h02},
    {4'd10, 3'b011, 6'h06, 6'h02, 6'h04}, // R10 free run
    {4'd10, 3'b011, 6'h00, 6'h04, 6'h00},
    {4'd9, 3'b001, 6'h3f, 6'h00, 6'h00},
    {4'd3, 3'b000, 6'h3f, 6'h00, 6'h08},
    {4'd3, 3'b000, 6'h00, 6'h08, 6'h00},
    {4'd11, 3'b100, 6'h00, 6'h00, 6'h00}, // R11 mode loads while idle
    {4'd8, 3'b100, 6'h08, 6'h00, 6'h08},
    {4'd5, 3'b100, 6'h09, 6'h00, 6'h01},  // R5 preempt
    {4'd6, 3'b100, 6'h09, 6'h00, 6'h01},  // R6 exclusive
    {4'd6, 3'b100, 6'h08, 6'h00, 6'h00},
    {4'd6, 3'b100, 6'h09, 6'h00, 6'h01},
    {4'd7, 3'b100, 6'h18, 6'h01, 6'h08},  // R7 resume
    {4'd7, 3'b100, 6'h18, 6'h08, 6'h10},
    {4'd8, 3'b100, 6'h12, 6'h10, 6'h02},  // R8 pool skips ch1
    {4'd5, 3'b100, 6'h03, 6'h02, 6'h01},
    {4'd8, 3'b000, 6'h02, 6'h01, 6'h02},
    {4'd11, 3'b100, 6'h03, 6'h00, 6'h02}, // R11 no change mid-burst
    {4'd11, 3'b100, 6'h02, 6'h02, 6'h02},
    {4'd11, 3'b100, 6'h03, 6'h00, 6'h01},
    {4'd7, 3'b000, 6'h02, 6'h01, 6'h02},
    {4'd11, 3'b000, 6'h00, 6'h02, 6'h00}
  };

  task automatic check(input int tag, input logic [5:0] exp);
    tests++;
    if (gnt_o !== exp) begin
      fails++;
      $display("FAIL R%0d: gnt_o=%h expected %h", tag, gnt_o, exp);
    end
  endtask

  task automatic slot(input logic [2:0] ctl, input logic [5:0] rq,
                      input logic [5:0] lst);
    @(negedge clk);
    ch1_high_i = ctl[2];
    free_run_i = ctl[1];
    suspend_i  = ctl[0];
    req_i      = rq;
    last_i     = lst;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(2, 6'h00);  // R2 quiet in reset
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(2, 6'h00);  // R2 first cycle after reset
    for (int i = 0; i < NV; i++) begin
      slot(VEC[i][20:18], VEC[i][17:12], VEC[i][11:6]);
      check(int'(VEC[i][24:21]), VEC[i][5:0]);
      tests++;
      if ($countones(gnt_o) > 1) begin  // R1
        fails++;
        $display("FAIL R1: gnt_o=%h expected at most one bit", gnt_o);
      end
    end
    // R2: reset from channel-1-high mode mid-burst restores round-robin
    slot(3'b100, 6'h00, 6'h00);
    slot(3'b100, 6'h09, 6'h00);
    check(5, 6'h01);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(2, 6'h00);
    @(negedge clk);
    rst = 1'b0;
    ch1_high_i = 1'b0;
    req_i = '0;
    last_i = '0;
    slot(3'b000, 6'h3f, 6'h3f);
    check(2, 6'h01);
    slot(3'b000, 6'h3f, 6'h3f);
    check(2, 6'h02);
    slot(3'b000, 6'h00, 6'h3f);
    check(2, 6'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule